// File: doc/BRIEF.md
# Dual-Core Doorbell Mailbox

This block lets two processor cores signal each other through a small register window. Each core has its own access port into the window, and the port index identifies the requesting core. Core 0 uses port 0 and core 1 uses port 1. Both cores share one 32-bit word of doorbell flags. A core raises flags by writing ones to a set offset and lowers them by writing ones to a clear offset.

Each core also owns a queue word that holds a single notify bit at bit 29. Only the other core can raise that bit, by writing a one to bit 29 of the queue word. Only a read of the queue word by its owner lowers it. Each core's interrupt output is high while its own notify bit is set. An identity offset returns a code that tells a core which of the two it is.

Read data is registered and appears on the requesting port one clock after the read strobe. It then holds until that port reads again. Both ports may access the block in the same cycle. The fixed rule for a same-cycle collision on one bit is that a raise beats a lowering.

Top module: `mbx_dual_core`

## Requirements
- R1: After reset, all doorbell flags, both notify bits, both interrupts and both read-data outputs are zero.
- R2: A read of offset 0x00 returns 0x55 on port 0 and 0xAA on port 1, one cycle after the read strobe.
- R3: A read of offset 0x04 returns the doorbell flags as they stood before that clock edge, and the flags change only on writes to 0x08 or 0x0C.
- R4: A write to offset 0x08 ORs the written word into the flags, and bits written as zero keep their value.
- R5: A write to offset 0x0C clears the flags where the written word has ones. When the same bit is set and cleared in one cycle, from any ports, the bit ends set.
- R6: The queue word of core n sits at offset 0x20 + n*0x10, so core 0 is at 0x20 and core 1 is at 0x30. A read returns the notify bit at bit 29, and all other bits read as zero.
- R7: A write with bit 29 high from the other core raises the notify bit of that queue. A write from the owning core, or a write with bit 29 low, leaves the notify bit unchanged.
- R8: A read of a queue word by its owning core returns the current value and then lowers the notify bit. A read by the other core leaves the bit set.
- R9: When a raise and an owner read of the same notify bit happen in one cycle, the read returns the old value and the bit ends set.
- R10: core_irq[n] is high exactly while the notify bit of core n is set.
- R11: Reads of unmapped offsets, and of 0x08 and 0x0C, return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2x8 | Byte offset for each core's port |
| bus_wr | input | 2 | Write strobe for each port |
| bus_wdata | input | 2x32 | Write data for each port |
| bus_rd | input | 2 | Read strobe for each port |
| bus_rdata | output | 2x32 | Registered read data for each port, held between reads |
| core_irq | output | 2 | Doorbell interrupt for each core |

## Verification
The assertions assume that each port's address is stable and word aligned whenever a strobe is high. They also assume that the strobes are never X after reset, and that the two ports may collide on any bit without further ordering. The stimulus changes inputs only at the falling edge. It uses only the seven offsets of interest, including an unmapped one. The random phase deliberately puts both ports on the same queue word and on the set and clear words together, so the set-wins rule is exercised under load.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int unsigned NCORE = 2;

  typedef enum logic [2:0] {
    K_NONE,
    K_IDENT,
    K_STAT,
    K_SETW,
    K_CLRW,
    K_QUEUE
  } kind_e;

  // Identity code: alternating bit pattern, phase chosen by the core index
  function automatic logic [7:0] ident_code(input logic core);
    return {4{core, ~core}};
  endfunction
endpackage

// File: rtl/mbx_decode.sv
`timescale 1ns/1ps
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int AW        = 8,
  parameter int OFF_IDENT = 'h00,
  parameter int OFF_STAT  = 'h04,
  parameter int OFF_SET   = 'h08,
  parameter int OFF_CLR   = 'h0C,
  parameter int QBASE     = 'h20,
  parameter int QSTRIDE   = 'h10,
  localparam int QW       = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic [AW-1:0] addr,
  output kind_e         kind,
  output logic [QW-1:0] qidx
);
  always_comb begin
    kind = K_NONE;
    qidx = '0;
    if (addr == AW'(OFF_IDENT)) kind = K_IDENT;
    if (addr == AW'(OFF_STAT))  kind = K_STAT;
    if (addr == AW'(OFF_SET))   kind = K_SETW;
    if (addr == AW'(OFF_CLR))   kind = K_CLRW;
    for (int n = 0; n < NCORE; n++) begin
      if (addr == AW'(QBASE + n * QSTRIDE)) begin
        kind = K_QUEUE;
        qidx = QW'(n);
      end
    end
  end
endmodule

// File: rtl/mbx_flags.sv
`timescale 1ns/1ps
module mbx_flags #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] flags
);
  logic [DW-1:0] flags_d;
  logic          flags_en;

  always_comb begin
    flags_en = (|set_vec) | (|clr_vec);
    flags_d  = (flags & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_d;
  end

  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));

  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(flags));
endmodule

// File: rtl/mbx_notify.sv
`timescale 1ns/1ps
module mbx_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic take,
  output logic pending
);
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = raise | take;
    pend_d  = raise | (pending & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (pend_en) pending <= pend_d;
  end

  a_r9_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> pending);

  a_r8_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !raise) |=> !pending);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise && !take) |=> $stable(pending));
endmodule

// File: rtl/mbx_dual_core.sv
`timescale 1ns/1ps
module mbx_dual_core
  import mbx_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 32,
  parameter int NOTIFY_BIT = 29,
  parameter int QBASE      = 'h20,
  parameter int QSTRIDE    = 'h10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCORE-1:0][AW-1:0]  bus_addr,
  input  logic [NCORE-1:0]          bus_wr,
  input  logic [NCORE-1:0][DW-1:0]  bus_wdata,
  input  logic [NCORE-1:0]          bus_rd,
  output logic [NCORE-1:0][DW-1:0]  bus_rdata,
  output logic [NCORE-1:0]          core_irq
);
  localparam int QW = (NCORE > 1) ? $clog2(NCORE) : 1;

  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  kind_e         kind [NCORE];
  logic [QW-1:0] qidx [NCORE];

  for (genvar p = 0; p < NCORE; p++) begin : g_dec
    mbx_decode #(.AW(AW), .QBASE(QBASE), .QSTRIDE(QSTRIDE)) u_dec (
      .addr (bus_addr[p]),
      .kind (kind[p]),
      .qidx (qidx[p])
    );
  end

  // Collect set/clear words and per-queue raise/take strobes
  logic [DW-1:0]    set_vec, clr_vec;
  logic [NCORE-1:0] raise, take, pending;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    raise   = '0;
    take    = '0;
    for (int p = 0; p < NCORE; p++) begin
      if (bus_wr[p] && kind[p] == K_SETW) set_vec = set_vec | bus_wdata[p];
      if (bus_wr[p] && kind[p] == K_CLRW) clr_vec = clr_vec | bus_wdata[p];
      for (int n = 0; n < NCORE; n++) begin
        if (kind[p] == K_QUEUE && int'(qidx[p]) == n) begin
          if (p != n && bus_wr[p] && bus_wdata[p][NOTIFY_BIT]) raise[n] = 1'b1;
          if (p == n && bus_rd[p]) take[n] = 1'b1;
        end
      end
    end
  end

  logic [DW-1:0] flags;

  mbx_flags #(.DW(DW)) u_flags (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  for (genvar n = 0; n < NCORE; n++) begin : g_q
    mbx_notify u_note (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .raise   (raise[n]),
      .take    (take[n]),
      .pending (pending[n])
    );
  end

  assign core_irq = pending;

  // Read path: next value per port, captured only on a read strobe
  logic [NCORE-1:0][DW-1:0] rdata_d;
  always_comb begin
    for (int p = 0; p < NCORE; p++) begin
      case (kind[p])
        K_IDENT: rdata_d[p] = DW'(ident_code(1'(p)));
        K_STAT:  rdata_d[p] = flags;
        K_QUEUE: rdata_d[p] = DW'(pending[qidx[p]]) << NOTIFY_BIT;
        default: rdata_d[p] = '0;
      endcase
    end
  end

  for (genvar p = 0; p < NCORE; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n)    bus_rdata[p] <= '0;
      else if (bus_rd[p]) bus_rdata[p] <= rdata_d[p];
    end

    a_r2_ident: assert property (@(posedge clk) disable iff (!rst_core_n)
      (bus_rd[p] && bus_addr[p] == '0) |=> (bus_rdata[p][7:0] == ((p == 0) ? 8'h55 : 8'hAA)));

    a_r3_stat_read: assert property (@(posedge clk) disable iff (!rst_core_n)
      (bus_rd[p] && kind[p] == K_STAT) |=> (bus_rdata[p] == $past(flags)));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
      (bus_rd[p] && (kind[p] == K_NONE || kind[p] == K_SETW || kind[p] == K_CLRW))
        |=> (bus_rdata[p] == '0));

    a_r10_irq_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
      (!raise[p] && !take[p]) |=> (core_irq[p] == $past(core_irq[p])));
  end
endmodule

// File: tb/tb_mbx_dual_core.sv
`timescale 1ns/1ps
module tb_mbx_dual_core;
  localparam int AW = 8;
  localparam int DW = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [1:0][AW-1:0]  bus_addr;
  logic [1:0]          bus_wr;
  logic [1:0][DW-1:0]  bus_wdata;
  logic [1:0]          bus_rd;
  logic [1:0][DW-1:0]  bus_rdata;
  logic [1:0]          core_irq;

  always #2.5 clk = ~clk;

  mbx_dual_core dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .core_irq(core_irq)
  );

  int total = 0;
  int bad   = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_flags;
  logic        m_q [2];
  logic [31:0] m_rd [2];
  string       m_tag [2];
  logic [31:0] sv, cv;
  logic        rs [2];
  logic        tk [2];

  function automatic logic [7:0] qaddr(input int n);
    return 8'(32 + 16 * n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = '0;
      for (int n = 0; n < 2; n++) begin
        m_q[n] = 1'b0; m_rd[n] = '0; m_tag[n] = "R1";
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (bus_rd[p]) begin
          m_rd[p] = 32'h0; m_tag[p] = "R11";
          if (bus_addr[p] == 8'h00) begin m_rd[p] = (p == 0) ? 32'h55 : 32'hAA; m_tag[p] = "R2"; end
          if (bus_addr[p] == 8'h04) begin m_rd[p] = m_flags; m_tag[p] = "R3"; end
          for (int n = 0; n < 2; n++)
            if (bus_addr[p] == qaddr(n)) begin m_rd[p] = {2'b00, m_q[n], 29'h0}; m_tag[p] = "R6"; end
        end
      end
      sv = '0; cv = '0;
      for (int p = 0; p < 2; p++) begin
        if (bus_wr[p] && bus_addr[p] == 8'h08) sv |= bus_wdata[p];
        if (bus_wr[p] && bus_addr[p] == 8'h0C) cv |= bus_wdata[p];
      end
      for (int n = 0; n < 2; n++) begin
        rs[n] = bus_wr[1-n] && bus_addr[1-n] == qaddr(n) && bus_wdata[1-n][29];
        tk[n] = bus_rd[n] && bus_addr[n] == qaddr(n);
      end
      m_flags = (m_flags & ~cv) | sv;
      for (int n = 0; n < 2; n++) m_q[n] = rs[n] | (m_q[n] & ~tk[n]);
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      for (int p = 0; p < 2; p++) begin
        chk(m_tag[p], bus_rdata[p], m_rd[p]);
        chk("R10", {31'h0, core_irq[p]}, {31'h0, m_q[p]});
      end
    end
  end

  task automatic idle();
    bus_addr = '0; bus_wr = '0; bus_wdata = '0; bus_rd = '0;
  endtask

  task automatic put(input int p, input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d);
    bus_addr[p] = a; bus_wr[p] = wr; bus_rd[p] = rd; bus_wdata[p] = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic logic [7:0] pick(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h04;
      2: return 8'h08;
      3: return 8'h0C;
      4: return 8'h20;
      5: return 8'h30;
      default: return 8'h44;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmp = 1'b1;

    // R1 reset state
    chk("R1", {30'h0, core_irq}, 32'h0);
    chk("R1", bus_rdata[0], 32'h0);
    put(0, 0, 1, 8'h04, 0); tick();
    chk("R1", bus_rdata[0], 32'h0);

    // R2 identity
    put(0, 0, 1, 8'h00, 0); put(1, 0, 1, 8'h00, 0); tick();
    chk("R2", bus_rdata[0], 32'h55);
    chk("R2", bus_rdata[1], 32'hAA);

    // R4 set accumulates
    put(0, 1, 0, 8'h08, 32'h0000_00F0); tick();
    put(1, 1, 0, 8'h08, 32'h8000_0001); tick();
    put(1, 0, 1, 8'h04, 0); tick();
    chk("R4", bus_rdata[1], 32'h8000_00F1);

    // R5 clear, then same-cycle set/clear on one bit
    put(0, 1, 0, 8'h0C, 32'h0000_0030); tick();
    put(0, 0, 1, 8'h04, 0); tick();
    chk("R5", bus_rdata[0], 32'h8000_00C1);
    put(0, 1, 0, 8'h08, 32'h0000_0010); put(1, 1, 0, 8'h0C, 32'h0000_0011); tick();
    put(0, 0, 1, 8'h04, 0); tick();
    chk("R5", bus_rdata[0], 32'h8000_00D0);

    // R7 raise by other core only
    put(1, 1, 0, 8'h20, 32'h2000_0000); tick();
    chk("R7", {30'h0, core_irq}, 32'h1);
    put(1, 1, 0, 8'h30, 32'h2000_0000); tick();
    chk("R7", {30'h0, core_irq}, 32'h1);
    put(0, 1, 0, 8'h30, 32'hDFFF_FFFF); tick();
    chk("R7", {30'h0, core_irq}, 32'h1);

    // R6 / R8 reads and read-to-clear
    put(1, 0, 1, 8'h20, 0); tick();
    chk("R6", bus_rdata[1], 32'h2000_0000);
    chk("R8", {30'h0, core_irq}, 32'h1);
    put(0, 0, 1, 8'h20, 0); tick();
    chk("R8", bus_rdata[0], 32'h2000_0000);
    chk("R8", {30'h0, core_irq}, 32'h0);
    put(0, 0, 1, 8'h20, 0); tick();
    chk("R8", bus_rdata[0], 32'h0);

    // R9 raise beats owner read in one cycle
    put(0, 1, 0, 8'h30, 32'h2000_0000); put(1, 0, 1, 8'h30, 0); tick();
    chk("R9", bus_rdata[1], 32'h0);
    chk("R9", {30'h0, core_irq}, 32'h2);
    put(1, 0, 1, 8'h30, 0); tick();
    chk("R9", bus_rdata[1], 32'h2000_0000);
    chk("R10", {30'h0, core_irq}, 32'h0);

    // R6 other bits of a queue word read zero
    put(1, 1, 0, 8'h20, 32'hFFFF_FFFF); tick();
    put(0, 0, 1, 8'h20, 0); tick();
    chk("R6", bus_rdata[0], 32'h2000_0000);

    // R11 unmapped and write-only offsets
    put(0, 0, 1, 8'h08, 0); put(1, 0, 1, 8'h44, 0); tick();
    chk("R11", bus_rdata[0], 32'h0);
    chk("R11", bus_rdata[1], 32'h0);
    put(0, 1, 0, 8'h44, 32'hFFFF_FFFF); tick();
    put(0, 0, 1, 8'h04, 0); tick();
    chk("R11", bus_rdata[0], 32'h8000_00D0);

    // Mixed traffic compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        int r;
        logic [31:0] d;
        r = $urandom_range(0, 9);
        d = $urandom;
        put(p, r < 4, r >= 3, pick($urandom_range(0, 6)), d);
      end
      tick();
    end

    run_cmp = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule